// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block sits in the execute stage of a small pipelined processor. Each cycle it looks at the instruction word the stage holds. It recognises two kinds of PC-relative branch: eight conditional forms and one unconditional form. A conditional form tests one of four condition flags, either the flag itself or its inverse. The block reports whether control moves and gives the byte address to fetch next. It does not read instruction memory, and it never writes a flag.

A taken branch costs one extra cycle. The register after the branch raises `flush` for one cycle. The fetch stage uses that pulse to discard the instruction it fetched behind the branch. If that discarded instruction reaches this block during the flush cycle, the block squashes it, so it has no effect. A branch that is not taken costs nothing. `target_pc` then holds the fall-through address.

Top module: `br_unit`

## Requirements
- R1: A word whose bits [15:11] equal 11100 is a conditional branch. Bits [10:8] choose the test: 000 Z set, 001 Z clear, 010 C set, 011 C clear, 100 OV set, 101 OV clear, 110 N set, 111 N clear. The `flags` input is {N, OV, Z, C} from bit 3 down to bit 0. When the test passes and the word is valid, `branch_taken` is 1 in the same cycle.
- R2: When the test of a valid conditional branch fails, `branch_taken` is 0 and `target_pc` equals `pc` + 2.
- R3: A valid word whose bits [15:11] equal 11010 is always taken, whatever the flags.
- R4: The target of a taken branch is `pc` + 2 + 2 × offset, wrapped to `PC_W` bits. The offset is the sign-extended value of bits [7:0] for a conditional branch and of bits [10:0] for the unconditional branch.
- R5: Any word that is not one of these encodings is not taken, and `target_pc` equals `pc` + 2.
- R6: `flush` is 1 in the cycle after each taken branch and in no other cycle. It never stays high for two cycles in a row.
- R7: A word presented while `flush` is 1 is squashed: it is not taken, `target_pc` is `pc` + 2, and no flush follows it.
- R8: While `instr_valid` is 0, nothing is taken and no flush follows.
- R9: While `rst_n` is low, and for two clock edges after it rises, nothing is taken and `flush` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | `instr` holds a real instruction this cycle |
| instr | input | 16 | Instruction word in the execute stage |
| pc | input | PC_W | Byte address of `instr` |
| flags | input | 4 | Condition flags {N, OV, Z, C} |
| branch_taken | output | 1 | Control moves to `target_pc` |
| target_pc | output | PC_W | Next fetch address (taken target or fall-through) |
| flush | output | 1 | One-cycle request to discard the instruction behind a taken branch |

## Verification
The embedded properties check the pipeline behaviour on every cycle. Every taken branch is followed by exactly one flush cycle, and a flush never occurs without a taken branch before it. Nothing is taken in a flush cycle or while the input is invalid. The unconditional form is always taken, a not-taken word falls through to `pc` + 2, and the target keeps the parity of the PC. The properties cannot show that each of the eight conditions picks the right flag with the right polarity, or that the two offset widths sign-extend and wrap correctly. The bench covers those with sweeps over every condition and flag combination, every 8-bit offset, a stride across the 11-bit offsets and all 256 upper opcode bytes.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int INSTR_W    = 16;
  localparam int COND_OFF_W = 8;
  localparam int UNC_OFF_W  = 11;
  localparam int FLAG_W     = 4;

  localparam logic [4:0] COND_OP = 5'b11100;
  localparam logic [4:0] UNC_OP  = 5'b11010;

  localparam int FLG_C  = 0;
  localparam int FLG_Z  = 1;
  localparam int FLG_OV = 2;
  localparam int FLG_N  = 3;

  typedef enum logic [1:0] {
    SEL_Z  = 2'b00,
    SEL_C  = 2'b01,
    SEL_OV = 2'b10,
    SEL_N  = 2'b11
  } flag_sel_e;

  typedef struct packed {
    logic                 is_cond;
    logic                 is_uncond;
    flag_sel_e            sel;
    logic                 invert;
    logic [UNC_OFF_W-1:0] off;
  } br_dec_t;
endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output br_dec_t            dec
);
  localparam int EXT_W = UNC_OFF_W - COND_OFF_W;

  logic [4:0] major;
  assign major = instr[INSTR_W-1:INSTR_W-5];

  always_comb begin
    dec = '0;
    if (major == COND_OP) begin
      dec.is_cond = 1'b1;
      dec.sel     = flag_sel_e'(instr[10:9]);
      dec.invert  = instr[8];
      dec.off     = {{EXT_W{instr[COND_OFF_W-1]}}, instr[COND_OFF_W-1:0]};
    end else if (major == UNC_OP) begin
      dec.is_uncond = 1'b1;
      dec.off       = instr[UNC_OFF_W-1:0];
    end
  end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
(
  input  br_dec_t           dec,
  input  logic [FLAG_W-1:0] flags,
  output logic              cond_true
);
  logic raw;

  always_comb begin
    case (dec.sel)
      SEL_Z:   raw = flags[FLG_Z];
      SEL_C:   raw = flags[FLG_C];
      SEL_OV:  raw = flags[FLG_OV];
      default: raw = flags[FLG_N];
    endcase
    cond_true = dec.is_cond & (raw ^ dec.invert);
  end
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc
  import br_pkg::*;
#(
  parameter int PC_W = 21
) (
  input  logic [PC_W-1:0]      pc,
  input  logic [UNC_OFF_W-1:0] off,
  input  logic                 take,
  output logic [PC_W-1:0]      target
);
  localparam int DISP_W = UNC_OFF_W + 1;

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] disp;

  generate
    if (PC_W > DISP_W) begin : g_ext
      assign disp = {{(PC_W-DISP_W){off[UNC_OFF_W-1]}}, off, 1'b0};
    end else begin : g_trunc
      logic [DISP_W-1:0] full;
      assign full = {off, 1'b0};
      assign disp = full[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    seq_pc = pc + PC_W'(2);
    target = take ? (seq_pc + disp) : seq_pc;
  end
endmodule

// File: rtl/br_unit.sv
module br_unit
  import br_pkg::*;
#(
  parameter int PC_W = 21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [PC_W-1:0]    pc,
  input  logic [FLAG_W-1:0]  flags,
  output logic               branch_taken,
  output logic [PC_W-1:0]    target_pc,
  output logic               flush
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_ok;
  br_dec_t                dec;
  logic                   cond_true;
  logic                   issue;
  logic                   flush_q;
  logic                   flush_d;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ok = rst_pipe[SYNC_STAGES-1];

  br_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  br_cond_eval u_eval (
    .dec       (dec),
    .flags     (flags),
    .cond_true (cond_true)
  );

  // a word in the shadow of a taken branch is squashed
  always_comb begin
    issue        = instr_valid & rst_ok & ~flush_q;
    branch_taken = issue & (dec.is_uncond | cond_true);
    flush_d      = branch_taken;
  end

  br_target_calc #(.PC_W(PC_W)) u_tgt (
    .pc     (pc),
    .off    (dec.off),
    .take   (branch_taken),
    .target (target_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= flush_d;
  end
  assign flush = flush_q;

  // R6
  taken_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken |=> flush);
  // R6
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);
  // R6
  flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(branch_taken));
  // R7
  shadow_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !branch_taken);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> !branch_taken);
  // R3
  uncond_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && rst_ok && !flush && instr[15:11] == UNC_OP) |-> branch_taken);
  // R5
  fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !branch_taken |-> target_pc == pc + PC_W'(2));
  // R4
  target_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    target_pc[0] == pc[0]);
endmodule

// File: tb/br_unit_tb_top.sv
module br_unit_tb_top;
  localparam int PC_W = 21;
  localparam longint MASK = (64'd1 << PC_W) - 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            instr_valid;
  logic [15:0]     instr;
  logic [PC_W-1:0] pc;
  logic [3:0]      flags;
  logic            branch_taken;
  logic [PC_W-1:0] target_pc;
  logic            flush;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  br_unit #(.PC_W(PC_W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_valid  (instr_valid),
    .instr        (instr),
    .pc           (pc),
    .flags        (flags),
    .branch_taken (branch_taken),
    .target_pc    (target_pc),
    .flush        (flush)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flags = {N, OV, Z, C}
  function automatic bit exp_take(input logic [15:0] i, input logic [3:0] f);
    if (i[15:11] == 5'b11010) return 1'b1;
    if (i[15:11] != 5'b11100) return 1'b0;
    case (i[10:8])
      3'd0: return f[1];
      3'd1: return !f[1];
      3'd2: return f[0];
      3'd3: return !f[0];
      3'd4: return f[2];
      3'd5: return !f[2];
      3'd6: return f[3];
      default: return !f[3];
    endcase
  endfunction

  function automatic longint exp_target(input logic [15:0] i, input logic [PC_W-1:0] p, input bit tk);
    longint disp;
    disp = 0;
    if (tk) begin
      if (i[15:11] == 5'b11010) disp = longint'($signed(i[10:0]));
      else                      disp = longint'($signed(i[7:0]));
    end
    return (longint'(p) + 2 + 2 * disp) & MASK;
  endfunction

  task automatic vec(input logic [15:0] i, input logic [PC_W-1:0] p,
                     input logic [3:0] f, input bit v, input string req);
    bit et;
    @(negedge clk);
    instr = i; pc = p; flags = f; instr_valid = v;
    #1;
    et = v && exp_take(i, f);
    check(branch_taken == et, req, longint'(branch_taken), longint'(et));
    check(target_pc == exp_target(i, p, et), req, longint'(target_pc), exp_target(i, p, et));
    @(negedge clk);
    instr_valid = 1'b0;
    #1;
    check(flush == et, "R6", longint'(flush), longint'(et));
    @(negedge clk);
    #1;
    check(flush == 1'b0, "R6", longint'(flush), 0);
  endtask

  initial begin
    rst_n = 1'b0; instr_valid = 1'b1; instr = 16'hD005; pc = 21'h100; flags = 4'hF;
    // R9 held reset: nothing taken, no flush
    repeat (3) @(negedge clk);
    #1;
    check(branch_taken == 1'b0, "R9", longint'(branch_taken), 0);
    check(flush == 1'b0, "R9", longint'(flush), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(branch_taken == 1'b0, "R9", longint'(branch_taken), 0);
    @(negedge clk);
    #1;
    check(branch_taken == 1'b0, "R9", longint'(branch_taken), 0);
    check(flush == 1'b0, "R9", longint'(flush), 0);
    instr_valid = 1'b0;
    repeat (2) @(negedge clk);

    // R1/R2 every condition x every flag combination x offset corners
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f++)
        for (int k = 0; k < 5; k++) begin
          logic [7:0] o;
          logic [15:0] w;
          o = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : (k == 2) ? 8'h7F : (k == 3) ? 8'h80 : 8'hFF;
          w = {5'b11100, 3'(c), o};
          vec(w, 21'h004000 + 21'(c * 64 + f * 2), 4'(f), 1'b1,
              exp_take(w, 4'(f)) ? "R1" : "R2");
        end

    // R4 every 8-bit offset, including wrap at both ends of the address space
    for (int o = 0; o < 256; o++) begin
      vec({8'b11100_000, 8'(o)}, 21'h000010, 4'b0010, 1'b1, "R4");
      vec({8'b11100_001, 8'(o)}, 21'h1FFFF0, 4'b0000, 1'b1, "R4");
    end

    // R3/R4 unconditional, stride through the 11-bit offsets, flags ignored
    for (int o = 0; o < 2048; o += 5)
      vec({5'b11010, 11'(o)}, 21'h000200 + 21'(o * 2), 4'(o), 1'b1, "R3");
    vec({5'b11010, 11'h3FF}, 21'h1FFF00, 4'h0, 1'b1, "R4");
    vec({5'b11010, 11'h400}, 21'h000002, 4'h0, 1'b1, "R4");

    // R5 every upper opcode byte: only the branch encodings move control
    for (int u = 0; u < 256; u++)
      vec({8'(u), 8'hA5}, 21'h010000 + 21'(u * 2), 4'(u) ^ 4'h6, 1'b1, "R5");

    // R8 invalid words do nothing
    vec(16'hD123, 21'h000400, 4'hF, 1'b0, "R8");
    vec(16'hE0F0, 21'h000402, 4'hF, 1'b0, "R8");

    // R7 taken branch followed by a taken-looking word in the flush cycle
    @(negedge clk);
    instr = 16'hD010; pc = 21'h000800; flags = 4'h0; instr_valid = 1'b1;
    #1;
    check(branch_taken == 1'b1, "R3", longint'(branch_taken), 1);
    @(negedge clk);
    instr = 16'hD7FF; pc = 21'h000822;
    #1;
    check(flush == 1'b1, "R6", longint'(flush), 1);
    check(branch_taken == 1'b0, "R7", longint'(branch_taken), 0);
    check(target_pc == 21'h000824, "R7", longint'(target_pc), 64'h824);
    @(negedge clk);
    instr_valid = 1'b0;
    #1;
    check(flush == 1'b0, "R7", longint'(flush), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule